// File: doc/BRIEF.md
# Random Number Generator Register Front-End

This block is the register-side front end of a random number generator. It has three 32-bit registers: control, status and data. Entropy words arrive on a valid/ready stream that stands in for the noise source and the conditioning logic. They are collected in a small FIFO and handed to software in bursts. One ready flag announces each full burst. Software then reads every word of the burst from the data register before it polls the flag again.

Seed faults and clock faults come in on dedicated test inputs. Each kind of fault has a live status bit and a sticky flag. A seed fault also discards everything buffered. The buffer does not refill until the fault has gone and software has cleared the sticky flag by writing zero to it.

Configuration is protected by a conditioning-reset bit. Software sets that bit, writes the configuration field, and then clears the bit while it sets the enable bit. Only that release write moves the field, including the noise-clock divider exponent, into the active configuration. Software picks the exponent N as the smallest value that brings the noise clock divided by 2^N to 48 MHz or below.

Top module: `rng_regfront`

## Requirements
- R1: Registers decode at byte offsets control 0x0, status 0x4 and data 0x8. Any other offset reads zero. After reset every register reads zero, and irq_o and cfg_o are zero.
- R2: The control register keeps only bit 2 (enable), bit 3 (interrupt enable), bit 5 (clock-fault detection off), bits 25:8 (configuration, with the divider exponent in bits 19:16) and bit 30 (conditioning reset). Every other bit reads zero.
- R3: The generator runs only while bit 2 is 1 and bit 30 is 0. While it does not run, the FIFO is empty, status bit 0 reads 0 and ent_ready_o is low.
- R4: While running, the block accepts entropy words until the FIFO holds DEPTH of them (4 by default). Status bit 0 then reads 1, and no further word is accepted while bit 0 is set.
- R5: With status bit 0 set, DEPTH reads of the data register return the words in the order they were accepted. Bit 0 then clears and refilling starts.
- R6: A data register read while status bit 0 is 0 returns zero and removes nothing from the FIFO.
- R7: Status bit 2 shows the seed-fault input one cycle late. A seed fault empties the FIFO, clears status bit 0 and sets sticky status bit 6. No word is accepted while bit 2 or bit 6 is set, and data reads meanwhile (for example a 12-read flush) return zero.
- R8: A status write with bit 6 at 0 clears bit 6 unless a seed fault is still present. A write of 1 leaves bit 6 unchanged. Refilling resumes once bit 6 has cleared.
- R9: While control bit 5 is 0, status bit 1 shows the clock-fault input and sets sticky bit 5. A status write with bit 5 at 0 clears bit 5. While control bit 5 is 1, a clock fault sets neither bit. A clock fault never changes data delivery.
- R10: cfg_o takes control bits 25:8, and div_exp_o takes bits 19:16, only from a control write that changes bit 30 from 1 to 0 with bit 2 set. Every other write leaves both outputs unchanged.
- R11: irq_o is high exactly when control bit 3 is set and at least one of status bits 0, 5 and 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the access |
| ent_valid_i | input | 1 | Entropy word offered |
| ent_data_i | input | 32 | Entropy word |
| ent_ready_o | output | 1 | Entropy word accepted when valid and ready are both high |
| seed_fault_i | input | 1 | Injected seed-fault condition |
| clk_fault_i | input | 1 | Injected clock-fault condition |
| irq_o | output | 1 | Interrupt request |
| cfg_o | output | 18 | Active configuration field |
| div_exp_o | output | 4 | Active noise-clock divider exponent |

## Verification
The bench goes after the edges of the burst. A design that let a read pop while the ready flag was clear would lose words, and the next burst would then start late in the counting sequence. It checks that a seed fault discards the FIFO and keeps it from refilling until the sticky flag has been cleared. It also checks that a clear written while the fault is still present does not take effect. A design that dropped either rule would either deliver stale words or go silent forever. Configuration writes made outside the release sequence must leave the active configuration alone, which catches a design that latches the field on every write. Masking the clock fault must suppress both clock bits, and masking the interrupt enable must hold irq_o low.

// File: rtl/rng_regfront_pkg.sv
package rng_regfront_pkg;
   localparam int REG_W     = 32;

   localparam int OFS_CTRL  = 'h0;
   localparam int OFS_STAT  = 'h4;
   localparam int OFS_DATA  = 'h8;

   localparam int CB_EN     = 2;
   localparam int CB_IE     = 3;
   localparam int CB_NOCED  = 5;
   localparam int CB_CRST   = 30;
   localparam int CFG_LSB   = 8;
   localparam int CFG_MSB   = 25;
   localparam int DIV_LSB   = 16;
   localparam int DIV_MSB   = 19;
   localparam int CFG_W     = CFG_MSB - CFG_LSB + 1;
   localparam int DIV_W     = DIV_MSB - DIV_LSB + 1;

   localparam int SB_RDY    = 0;
   localparam int SB_CCUR   = 1;
   localparam int SB_SCUR   = 2;
   localparam int SB_CSTK   = 5;
   localparam int SB_SSTK   = 6;

   localparam logic [REG_W-1:0] CR_MASK =
      (32'h1 << CB_EN) | (32'h1 << CB_IE) | (32'h1 << CB_NOCED) |
      (32'h1 << CB_CRST) | (((32'h1 << CFG_W) - 32'h1) << CFG_LSB);
endpackage

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush_i,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] count_q;
   logic          do_push, do_pop;

   initial begin : elab_chk
      if (DEPTH < 1) $error("rng_word_fifo: DEPTH must be at least 1");
      if (W < 1)     $error("rng_word_fifo: W must be at least 1");
   end

   assign full_o  = (count_q == CW'(DEPTH));
   assign empty_o = (count_q == '0);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count_q <= '0;
      else if (flush_i)            count_q <= '0;
      else if (do_push && !do_pop) count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (do_push) word_q <= din_i;
         end
         assign dout_o = word_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;

         always_ff @(posedge clk) begin
            if (do_push) mem_q[wp_q] <= din_i;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q <= '0;
               rp_q <= '0;
            end else if (flush_i) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
         end
         assign dout_o = mem_q[rp_q];
      end
   endgenerate
endmodule

// File: rtl/rng_ctl_reg.sv
module rng_ctl_reg
   import rng_regfront_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] ctl_o,
   output logic [CFG_W-1:0] cfg_o,
   output logic             run_o
);
   logic [REG_W-1:0] ctl_q;
   logic [CFG_W-1:0] cfg_q;
   logic             release_w;

   // Release: conditioning reset goes 1 -> 0 while enable is written 1.
   assign release_w = wr_i & ctl_q[CB_CRST] & ~wdata_i[CB_CRST] & wdata_i[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cfg_q <= '0;
      end else begin
         if (wr_i)      ctl_q <= wdata_i & CR_MASK;
         if (release_w) cfg_q <= wdata_i[CFG_MSB:CFG_LSB];
      end
   end

   assign ctl_o = ctl_q;
   assign cfg_o = cfg_q;
   assign run_o = ctl_q[CB_EN] & ~ctl_q[CB_CRST];
endmodule

// File: rtl/rng_err_track.sv
module rng_err_track (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_fault_i,
   input  logic clk_fault_i,
   input  logic noced_i,
   input  logic stat_wr_i,
   input  logic wr_seed_bit_i,
   input  logic wr_clk_bit_i,
   output logic seed_cur_o,
   output logic seed_stk_o,
   output logic clk_cur_o,
   output logic clk_stk_o
);
   logic s_cur_q, s_stk_q, c_cur_q, c_stk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_cur_q <= 1'b0;
         s_stk_q <= 1'b0;
         c_cur_q <= 1'b0;
         c_stk_q <= 1'b0;
      end else begin
         s_cur_q <= seed_fault_i;
         c_cur_q <= clk_fault_i & ~noced_i;
         // a live condition wins over a clear written in the same cycle
         if (s_cur_q)                         s_stk_q <= 1'b1;
         else if (stat_wr_i && !wr_seed_bit_i) s_stk_q <= 1'b0;
         if (c_cur_q)                         c_stk_q <= 1'b1;
         else if (stat_wr_i && !wr_clk_bit_i)  c_stk_q <= 1'b0;
      end
   end

   assign seed_cur_o = s_cur_q;
   assign seed_stk_o = s_stk_q;
   assign clk_cur_o  = c_cur_q;
   assign clk_stk_o  = c_stk_q;
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
   import rng_regfront_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   input  logic              ent_valid_i,
   input  logic [REG_W-1:0]  ent_data_i,
   output logic              ent_ready_o,
   input  logic              seed_fault_i,
   input  logic              clk_fault_i,
   output logic              irq_o,
   output logic [CFG_W-1:0]  cfg_o,
   output logic [DIV_W-1:0]  div_exp_o
);
   initial begin : elab_chk
      if (ADDR_W < 4) $error("rng_regfront: ADDR_W must reach offset 0x8");
      if (DEPTH < 1)  $error("rng_regfront: DEPTH must be at least 1");
   end

   logic             sel_ctl, sel_stat, sel_data;
   logic [REG_W-1:0] ctl_q, stat_w, fifo_dout;
   logic             run_w, s_cur, s_stk, c_cur, c_stk;
   logic             fifo_empty, fifo_full, flush_w, push_w, pop_w;
   logic             drdy_q;

   assign sel_ctl  = (bus_addr_i == ADDR_W'(OFS_CTRL));
   assign sel_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
   assign sel_data = (bus_addr_i == ADDR_W'(OFS_DATA));

   rng_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_valid_i & bus_write_i & sel_ctl),
      .wdata_i (bus_wdata_i),
      .ctl_o   (ctl_q),
      .cfg_o   (cfg_o),
      .run_o   (run_w)
   );

   rng_err_track u_err (
      .clk           (clk),
      .rst_n         (rst_n),
      .seed_fault_i  (seed_fault_i),
      .clk_fault_i   (clk_fault_i),
      .noced_i       (ctl_q[CB_NOCED]),
      .stat_wr_i     (bus_valid_i & bus_write_i & sel_stat),
      .wr_seed_bit_i (bus_wdata_i[SB_SSTK]),
      .wr_clk_bit_i  (bus_wdata_i[SB_CSTK]),
      .seed_cur_o    (s_cur),
      .seed_stk_o    (s_stk),
      .clk_cur_o     (c_cur),
      .clk_stk_o     (c_stk)
   );

   assign flush_w     = ~run_w | s_cur;
   assign ent_ready_o = run_w & ~s_cur & ~s_stk & ~drdy_q & ~fifo_full;
   assign push_w      = ent_valid_i & ent_ready_o;
   assign pop_w       = bus_valid_i & ~bus_write_i & sel_data & drdy_q & ~fifo_empty;

   rng_word_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_w),
      .push_i  (push_w),
      .din_i   (ent_data_i),
      .pop_i   (pop_w),
      .dout_o  (fifo_dout),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   // burst flag: raised on a full FIFO, dropped once the burst is drained
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          drdy_q <= 1'b0;
      else if (flush_w)    drdy_q <= 1'b0;
      else if (fifo_full)  drdy_q <= 1'b1;
      else if (fifo_empty) drdy_q <= 1'b0;
   end

   always_comb begin
      stat_w          = '0;
      stat_w[SB_RDY]  = drdy_q;
      stat_w[SB_CCUR] = c_cur;
      stat_w[SB_SCUR] = s_cur;
      stat_w[SB_CSTK] = c_stk;
      stat_w[SB_SSTK] = s_stk;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (sel_ctl)       bus_rdata_o = ctl_q;
      else if (sel_stat) bus_rdata_o = stat_w;
      else if (sel_data && drdy_q && !fifo_empty) bus_rdata_o = fifo_dout;
   end

   assign irq_o     = ctl_q[CB_IE] & (drdy_q | c_stk | s_stk);
   assign div_exp_o = cfg_o[DIV_MSB-CFG_LSB:DIV_LSB-CFG_LSB];
endmodule

// File: rtl/rng_regfront_chk.sv
module rng_regfront_chk
   import rng_regfront_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_w,
   input logic              drdy_q,
   input logic              ent_ready_o,
   input logic              s_cur,
   input logic              s_stk,
   input logic              c_stk,
   input logic              bus_valid_i,
   input logic              bus_write_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [REG_W-1:0]  bus_wdata_i,
   input logic [REG_W-1:0]  bus_rdata_o,
   input logic [REG_W-1:0]  ctl_q,
   input logic [CFG_W-1:0]  cfg_o,
   input logic              irq_o
);
   logic rel_w, dread_w;
   assign rel_w = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(OFS_CTRL)) &&
                  ctl_q[CB_CRST] && !bus_wdata_i[CB_CRST] && bus_wdata_i[CB_EN];
   assign dread_w = bus_valid_i && !bus_write_i && (bus_addr_i == ADDR_W'(OFS_DATA));

   p_hold_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w |=> !drdy_q);
   p_hold_noaccept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w |-> !ent_ready_o);
   p_no_push_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drdy_q |-> !ent_ready_o);
   p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dread_w && !drdy_q) |-> (bus_rdata_o == '0));
   p_seed_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s_cur |=> (!drdy_q && s_stk));
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_w |=> $stable(cfg_o));
   p_cfg_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rel_w |=> (cfg_o == $past(bus_wdata_i[CFG_MSB:CFG_LSB])));
   p_irq_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CB_IE] && (s_stk || c_stk)) |-> irq_o);
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[CB_IE] |-> !irq_o);
endmodule

bind rng_regfront rng_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_w       (run_w),
   .drdy_q      (drdy_q),
   .ent_ready_o (ent_ready_o),
   .s_cur       (s_cur),
   .s_stk       (s_stk),
   .c_stk       (c_stk),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .ctl_q       (ctl_q),
   .cfg_o       (cfg_o),
   .irq_o       (irq_o)
);

// File: tb/sim_rng_regfront.sv
`timescale 1ns/1ps
module sim_rng_regfront;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        ent_valid = 1'b1;
   logic [31:0] ent_data = 32'h1000;
   logic        ent_ready, seed_fault = 1'b0, clk_fault = 1'b0, irq;
   logic [17:0] cfg;
   logic [3:0]  div_exp;

   int n_chk = 0, n_bad = 0;
   logic [31:0] exp_word = 32'h1000;
   logic        finished = 1'b0;

   always #4 clk = ~clk;

   rng_regfront u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .ent_valid_i(ent_valid), .ent_data_i(ent_data), .ent_ready_o(ent_ready),
      .seed_fault_i(seed_fault), .clk_fault_i(clk_fault), .irq_o(irq),
      .cfg_o(cfg), .div_exp_o(div_exp));

   // entropy source: next value only after an accepted handshake
   initial begin
      logic take;
      forever begin
         @(negedge clk); #2;
         take = ent_valid && ent_ready;
         @(posedge clk); #1;
         if (take) ent_data = ent_data + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic read_burst(input string req);
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         rd(4'h8, d);
         chk(req, d, exp_word);
         exp_word = exp_word + 1;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(4'h0, d); chk("R1 ctrl reset", d, 32'h0);
      rd(4'h4, d); chk("R1 status reset", d, 32'h0);
      rd(4'hC, d); chk("R1 unmapped", d, 32'h0);
      chk("R1 irq reset", {31'h0, irq}, 32'h0);
      chk("R1 cfg reset", {14'h0, cfg}, 32'h0);
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); chk("R2 ctrl mask", d, 32'h43FF_FF2C);
      wr(4'h0, 32'h0);
      chk("R10 cfg after plain write", {14'h0, cfg}, 32'h0);
   endtask

   task automatic t_config;
      logic [31:0] d;
      wr(4'h0, 32'h00F4_0F00);           // field written without the reset held
      chk("R10 no latch", {14'h0, cfg}, 32'h0);
      wr(4'h0, 32'h40F4_0F00);           // hold conditioning reset
      chk("R10 held", {14'h0, cfg}, 32'h0);
      wr(4'h0, 32'h00F4_0F04);           // release with enable
      chk("R10 cfg latched", {14'h0, cfg}, 32'h0000_F40F);
      chk("R10 div exponent", {28'h0, div_exp}, 32'h4);
      wr(4'h0, 32'h0180_1004);           // new field, no release
      chk("R10 cfg unchanged", {14'h0, cfg}, 32'h0000_F40F);
      rd(4'h0, d); chk("R2 ctrl readback", d, 32'h0180_1004);
   endtask

   task automatic t_burst;
      logic [31:0] d;
      idle(12);
      rd(4'h4, d); chk("R4 ready after fill", d, 32'h1);
      chk("R4 no accept in burst", {31'h0, ent_ready}, 32'h0);
      read_burst("R5 burst order");
      rd(4'h8, d); chk("R6 read past burst", d, 32'h0);
      idle(12);
      rd(4'h4, d); chk("R5 refill ready", d, 32'h1);
   endtask

   task automatic t_hold;
      logic [31:0] d;
      wr(4'h0, 32'h0180_1000);           // disable: flush the full FIFO
      exp_word = exp_word + 4;
      idle(3);
      rd(4'h4, d); chk("R3 disabled ready", d, 32'h0);
      chk("R3 disabled no accept", {31'h0, ent_ready}, 32'h0);
      rd(4'h8, d); chk("R3 disabled data", d, 32'h0);
      ent_valid = 1'b0;
      wr(4'h0, 32'h0180_1004);
      @(negedge clk); ent_valid = 1'b1;
      @(negedge clk);
      @(negedge clk); ent_valid = 1'b0;  // exactly two words buffered
      rd(4'h8, d); chk("R6 partial read zero", d, 32'h0);
      rd(4'h4, d); chk("R6 not ready", d, 32'h0);
      ent_valid = 1'b1;
      idle(10);
      read_burst("R6 no word lost");
      idle(12);
   endtask

   task automatic t_seed;
      logic [31:0] d;
      @(negedge clk); seed_fault = 1'b1;
      exp_word = exp_word + 4;           // full FIFO discarded
      idle(3);
      rd(4'h4, d); chk("R7 fault status", d, 32'h44);
      @(negedge clk); seed_fault = 1'b0;
      idle(12);
      rd(4'h4, d); chk("R7 blocked by sticky", d, 32'h40);
      for (int i = 0; i < 12; i++) begin
         rd(4'h8, d); chk("R7 flush read", d, 32'h0);
      end
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, d); chk("R8 write one keeps", d, 32'h40);
      wr(4'h4, 32'h0);
      rd(4'h4, d); chk("R8 cleared", d, 32'h0);
      idle(12);
      read_burst("R8 refill after clear");
      idle(12);
      @(negedge clk); seed_fault = 1'b1;
      exp_word = exp_word + 4;
      idle(3);
      wr(4'h4, 32'h0);
      rd(4'h4, d); chk("R8 clear while present", d, 32'h44);
      @(negedge clk); seed_fault = 1'b0;
      idle(3);
      wr(4'h4, 32'h0);
      idle(12);
      read_burst("R8 recovery burst");
      idle(12);
   endtask

   task automatic t_clock;
      logic [31:0] d;
      @(negedge clk); clk_fault = 1'b1;
      idle(3);
      rd(4'h4, d); chk("R9 clock fault", d, 32'h23);
      read_burst("R9 data unaffected");
      @(negedge clk); clk_fault = 1'b0;
      idle(12);
      rd(4'h4, d); chk("R9 sticky remains", d, 32'h21);
      wr(4'h4, 32'h0);
      rd(4'h4, d); chk("R9 sticky cleared", d, 32'h1);
      wr(4'h0, 32'h0180_1024);
      @(negedge clk); clk_fault = 1'b1;
      idle(3);
      rd(4'h4, d); chk("R9 detection off", d, 32'h1);
      @(negedge clk); clk_fault = 1'b0;
      idle(2);
   endtask

   task automatic t_irq;
      chk("R11 masked", {31'h0, irq}, 32'h0);
      wr(4'h0, 32'h0180_100C);
      @(negedge clk);
      chk("R11 ready irq", {31'h0, irq}, 32'h1);
      read_burst("R11 burst");
      @(negedge clk); @(negedge clk);
      chk("R11 drained irq low", {31'h0, irq}, 32'h0);
      @(negedge clk); seed_fault = 1'b1;
      idle(3);
      @(negedge clk);
      chk("R11 seed irq", {31'h0, irq}, 32'h1);
      seed_fault = 1'b0;
   endtask

   task automatic report;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_config();
      t_burst();
      t_hold();
      t_seed();
      t_clock();
      t_irq();
      finished = 1'b1;
      report();
      $finish;
   end
endmodule